// File: doc/BRIEF.md
# Serial Configuration Register Slave with Readback

This block is the configuration port of a mixed-signal device. An external controller drives three wires: an active-low select, a shift clock and a serial data line. Each 16-bit frame carries an 8-bit register address and then 8 bits of data, both most significant bit first. The block keeps fifteen 8-bit control registers, each with a fixed reset value, and presents their contents on a flat output bus so that the rest of the chip can use them.

All three serial wires are brought into the system clock domain through synchronizer chains, and edge detection runs there. A write to the control register at address 00h can restore every register to its default and then clear its own request bit. The same register can put the block into a readback mode. In readback mode the controller sends an address, and the block shifts the contents of that register out during the data half of the frame. The output pin it uses normally mirrors an over-range flag.

Top module: `scfg_serial_regs`

## Requirements
- R1: After the hardware reset input has been high, every register holds 00h except address 25h, which holds 50h, and address 42h, which holds 08h. The implemented addresses are 00h, 01h, 03h, 25h, 26h, 3Dh, 3Fh, 40h, 41h, 42h, 43h, 4Ah, BFh, CFh and DFh. Byte k of `regs_q` (bits 8k+7..8k) holds the k-th of these addresses in this ascending order.
- R2: While `cfg_sel_n` is low, `cfg_sdi` is sampled on each falling edge of `cfg_sck`. The first 8 samples form the address and the next 8 form the data, both MSB first. The write takes effect after the 16th falling edge.
- R3: Several frames sent back to back in one low period of `cfg_sel_n` are each written, in order.
- R4: Bits left over beyond the last complete frame when `cfg_sel_n` rises are discarded. The next select period starts a fresh frame.
- R5: `cfg_sck` edges while `cfg_sel_n` is high change no register.
- R6: A write to address 00h with data bit 1 set returns all registers to their R1 defaults, address 00h included. Bit 1 therefore reads back as 0 afterwards.
- R7: While bit 0 of address 00h (readback enable) is 1, writes to any address other than 00h are ignored.
- R8: Writes to address 00h are still accepted in readback mode, so writing 00h there leaves the mode.
- R9: In readback mode, bits 7 down to 0 of the addressed register appear on `sdout_ovr` during the data half of the frame. Each bit is valid at the falling edge of `cfg_sck` that samples data bits 7 to 0.
- R10: In readback mode, address 00h and unimplemented addresses read back as 00h. A write to an unimplemented address changes no register.
- R11: `sdout_ovr` equals `ovr_flag` whenever readback is off, and also whenever `cfg_sel_n` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; serial inputs are oversampled on it |
| hw_reset | input | 1 | Active-high asynchronous reset to defaults |
| cfg_sel_n | input | 1 | Serial select, active low |
| cfg_sck | input | 1 | Serial shift clock |
| cfg_sdi | input | 1 | Serial data in |
| ovr_flag | input | 1 | Over-range flag from the converter |
| sdout_ovr | output | 1 | Readback data, or the over-range flag |
| regs_q | output | 120 | Register contents, byte k = k-th implemented address |

## Verification
The bench attacks frame alignment. It sends a partial frame followed by a fresh select period; a design that keeps stale bits would write a shifted address and data in the second period. It writes to other registers while readback is on. A design with no write lockout would corrupt those registers, and one that also locked out address 00h could never leave the mode. It reads back address 00h and unimplemented addresses, and it checks that the pin returns to the over-range flag when select rises. A design that drove readback bits late, or that left the pin in readback, would show a wrong bit at a falling-edge sample.

// File: rtl/scfg_pkg.sv
package scfg_pkg;
  localparam int CFG_ADDR_W = 8;
  localparam int CFG_DATA_W = 8;
  localparam int CFG_NREG   = 15;

  // Address of implemented register slot idx (slot 0 is the control register).
  function automatic logic [7:0] cfg_reg_addr(input int idx);
    logic [7:0] a;
    case (idx)
      0:  a = 8'h00;
      1:  a = 8'h01;
      2:  a = 8'h03;
      3:  a = 8'h25;
      4:  a = 8'h26;
      5:  a = 8'h3D;
      6:  a = 8'h3F;
      7:  a = 8'h40;
      8:  a = 8'h41;
      9:  a = 8'h42;
      10: a = 8'h43;
      11: a = 8'h4A;
      12: a = 8'hBF;
      13: a = 8'hCF;
      14: a = 8'hDF;
      default: a = 8'h00;
    endcase
    return a;
  endfunction

  function automatic logic [7:0] cfg_reg_default(input logic [7:0] addr);
    logic [7:0] v;
    case (addr)
      8'h25:   v = 8'h50;
      8'h42:   v = 8'h08;
      default: v = 8'h00;
    endcase
    return v;
  endfunction

  function automatic logic cfg_is_mapped(input logic [7:0] addr);
    logic hit;
    hit = 1'b0;
    for (int i = 0; i < CFG_NREG; i++)
      if (addr == cfg_reg_addr(i)) hit = 1'b1;
    return hit;
  endfunction
endpackage

// File: rtl/scfg_in_sync.sv
module scfg_in_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d_raw,
  output logic [N-1:0] d_s,
  output logic [N-1:0] d_prev
);
  for (genvar b = 0; b < N; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    logic              last_q;
    always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
        chain  <= {STAGES{RST_VAL[b]}};
        last_q <= RST_VAL[b];
      end else begin
        chain  <= {chain[STAGES-2:0], d_raw[b]};
        last_q <= chain[STAGES-1];
      end
    end
    assign d_s[b]    = chain[STAGES-1];
    assign d_prev[b] = last_q;
  end
endmodule

// File: rtl/scfg_frame_rx.sv
module scfg_frame_rx #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  localparam int FRAME_W = ADDR_W + DATA_W,
  localparam int CNT_W   = $clog2(FRAME_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sen_s,
  input  logic              sclk_fall,
  input  logic              sdi_s,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic [ADDR_W-1:0] addr_q,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              data_phase
);
  logic [FRAME_W-1:0] sh;
  logic [FRAME_W-1:0] sh_next;

  assign sh_next = {sh[FRAME_W-2:0], sdi_s};

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      bit_cnt <= '0;
      sh      <= '0;
      addr_q  <= '0;
      wr_stb  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (sen_s) begin
        bit_cnt <= '0;
      end else if (sclk_fall) begin
        sh <= sh_next;
        if (bit_cnt == CNT_W'(ADDR_W - 1))
          addr_q <= sh_next[ADDR_W-1:0];
        if (bit_cnt == CNT_W'(FRAME_W - 1)) begin
          bit_cnt <= '0;
          wr_stb  <= 1'b1;
          wr_addr <= sh_next[FRAME_W-1:DATA_W];
          wr_data <= sh_next[DATA_W-1:0];
        end else begin
          bit_cnt <= bit_cnt + CNT_W'(1);
        end
      end
    end
  end

  assign data_phase = !sen_s && (bit_cnt >= CNT_W'(ADDR_W));
endmodule

// File: rtl/scfg_reg_bank.sv
module scfg_reg_bank
  import scfg_pkg::*;
#(
  parameter int ADDR_W = CFG_ADDR_W,
  parameter int DATA_W = CFG_DATA_W,
  parameter int NREG   = CFG_NREG
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_stb,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic [ADDR_W-1:0]      rd_addr,
  output logic [NREG*DATA_W-1:0] regs_flat,
  output logic                   readout_en,
  output logic [DATA_W-1:0]      rd_data,
  output logic                   wr_commit,
  output logic                   sw_reset
);
  localparam int RESET_BIT = 1;
  localparam int READ_BIT  = 0;

  logic ctrl_hit;
  assign ctrl_hit  = (wr_addr == '0);
  assign sw_reset  = wr_stb && ctrl_hit && wr_data[RESET_BIT];
  assign wr_commit = wr_stb && !sw_reset && cfg_is_mapped(8'(wr_addr))
                     && (!readout_en || ctrl_hit);

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [ADDR_W-1:0] RADDR = ADDR_W'(cfg_reg_addr(i));
    localparam logic [DATA_W-1:0] RDEF  = DATA_W'(cfg_reg_default(cfg_reg_addr(i)));
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk or posedge rst) begin
      if (rst)                                q <= RDEF;
      else if (sw_reset)                      q <= RDEF;
      else if (wr_commit && wr_addr == RADDR) q <= wr_data;
    end
    assign regs_flat[i*DATA_W +: DATA_W] = q;
  end

  assign readout_en = regs_flat[READ_BIT];

  always_comb begin
    rd_data = '0;
    for (int i = 1; i < NREG; i++)
      if (rd_addr == ADDR_W'(cfg_reg_addr(i)))
        rd_data = regs_flat[i*DATA_W +: DATA_W];
  end
endmodule

// File: rtl/scfg_serial_regs.sv
module scfg_serial_regs
  import scfg_pkg::*;
#(
  parameter int ADDR_W      = CFG_ADDR_W,
  parameter int DATA_W      = CFG_DATA_W,
  parameter int NREG        = CFG_NREG,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   hw_reset,
  input  logic                   cfg_sel_n,
  input  logic                   cfg_sck,
  input  logic                   cfg_sdi,
  input  logic                   ovr_flag,
  output logic                   sdout_ovr,
  output logic [NREG*DATA_W-1:0] regs_q
);
  localparam int FRAME_W = ADDR_W + DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W);
  localparam int BIDX_W  = $clog2(DATA_W);

  // Which data bit goes out for a given frame bit count (MSB first).
  function automatic logic [BIDX_W-1:0] out_bit_index(input logic [CNT_W-1:0] cnt);
    return BIDX_W'(FRAME_W - 1 - int'(cnt));
  endfunction

  logic [2:0] raw_in, syn, syn_prev;
  logic sen_s, sclk_s, sdi_s, sen_prev, sclk_prev;
  logic sclk_fall, sclk_rise, sen_rise;

  assign raw_in = {cfg_sdi, cfg_sck, cfg_sel_n};

  scfg_in_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) sync_i (
    .clk(clk), .rst(hw_reset), .d_raw(raw_in), .d_s(syn), .d_prev(syn_prev)
  );

  assign sen_s     = syn[0];
  assign sclk_s    = syn[1];
  assign sdi_s     = syn[2];
  assign sen_prev  = syn_prev[0];
  assign sclk_prev = syn_prev[1];
  assign sclk_fall = !sclk_s && sclk_prev;
  assign sclk_rise = sclk_s && !sclk_prev;
  assign sen_rise  = sen_s && !sen_prev;

  logic [CNT_W-1:0]  bit_cnt;
  logic [ADDR_W-1:0] addr_q, wr_addr;
  logic [DATA_W-1:0] wr_data, rd_data;
  logic wr_stb, data_phase, readout_en, wr_commit, sw_reset;

  scfg_frame_rx #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) rx_i (
    .clk(clk), .rst(hw_reset), .sen_s(sen_s), .sclk_fall(sclk_fall), .sdi_s(sdi_s),
    .bit_cnt(bit_cnt), .addr_q(addr_q), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .data_phase(data_phase)
  );

  scfg_reg_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NREG(NREG)) bank_i (
    .clk(clk), .rst(hw_reset), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(addr_q), .regs_flat(regs_q), .readout_en(readout_en), .rd_data(rd_data),
    .wr_commit(wr_commit), .sw_reset(sw_reset)
  );

  // Readback bit launched on the serial clock rising edge, captured on the falling edge.
  logic sdout_bit;
  always_ff @(posedge clk or posedge hw_reset) begin
    if (hw_reset)                       sdout_bit <= 1'b0;
    else if (sclk_rise && data_phase)   sdout_bit <= rd_data[out_bit_index(bit_cnt)];
  end

  assign sdout_ovr = (readout_en && data_phase) ? sdout_bit : ovr_flag;
endmodule

// File: rtl/scfg_serial_regs_chk.sv
module scfg_serial_regs_chk #(
  parameter int CNT_W  = 4,
  parameter int ADDR_W = 8,
  parameter int REGS_W = 120,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              hw_reset,
  input logic              wr_stb,
  input logic              sclk_fall,
  input logic              sen_s,
  input logic              sen_rise,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic              wr_commit,
  input logic              readout_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              sw_reset,
  input logic [REGS_W-1:0] regs_q,
  input logic              sdout_ovr,
  input logic              ovr_flag
);
  assert_write_after_fall_R2: assert property (@(posedge clk) disable iff (hw_reset)
    wr_stb |-> $past(sclk_fall));

  assert_partial_drop_R4: assert property (@(posedge clk) disable iff (hw_reset)
    sen_rise |=> (bit_cnt == '0));

  assert_idle_no_change_R5: assert property (@(posedge clk) disable iff (hw_reset)
    (sen_s && $past(sen_s)) |=> $stable(regs_q));

  assert_selfclear_R6: assert property (@(posedge clk) disable iff (hw_reset)
    sw_reset |=> (regs_q[DATA_W-1:0] == '0));

  assert_lockout_R7: assert property (@(posedge clk) disable iff (hw_reset)
    (wr_commit && readout_en) |-> (wr_addr == '0));

  assert_ovr_pass_R11: assert property (@(posedge clk) disable iff (hw_reset)
    (!readout_en || sen_s) |-> (sdout_ovr == ovr_flag));
endmodule

bind scfg_serial_regs scfg_serial_regs_chk #(
  .CNT_W(CNT_W), .ADDR_W(ADDR_W), .REGS_W(NREG*DATA_W), .DATA_W(DATA_W)
) chk_i (
  .clk(clk), .hw_reset(hw_reset), .wr_stb(wr_stb), .sclk_fall(sclk_fall),
  .sen_s(sen_s), .sen_rise(sen_rise), .bit_cnt(bit_cnt), .wr_commit(wr_commit),
  .readout_en(readout_en), .wr_addr(wr_addr), .sw_reset(sw_reset),
  .regs_q(regs_q), .sdout_ovr(sdout_ovr), .ovr_flag(ovr_flag)
);

// File: tb/scfg_serial_regs_tb_top.sv
module scfg_serial_regs_tb_top;
  localparam int NR   = 15;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic hw_reset = 1'b1;
  logic cfg_sel_n = 1'b1, cfg_sck = 1'b0, cfg_sdi = 1'b0, ovr_flag = 1'b0;
  logic sdout_ovr;
  logic [NR*8-1:0] regs_q;

  int n_checks = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] exp_r [NR];

  always #4 clk = ~clk;

  scfg_serial_regs dut_i (
    .clk(clk), .hw_reset(hw_reset), .cfg_sel_n(cfg_sel_n), .cfg_sck(cfg_sck),
    .cfg_sdi(cfg_sdi), .ovr_flag(ovr_flag), .sdout_ovr(sdout_ovr), .regs_q(regs_q)
  );

  function automatic int slot_of(input logic [7:0] a);
    case (a)
      8'h00: return 0;  8'h01: return 1;  8'h03: return 2;  8'h25: return 3;
      8'h26: return 4;  8'h3D: return 5;  8'h3F: return 6;  8'h40: return 7;
      8'h41: return 8;  8'h42: return 9;  8'h43: return 10; 8'h4A: return 11;
      8'hBF: return 12; 8'hCF: return 13; 8'hDF: return 14;
      default: return -1;
    endcase
  endfunction

  function automatic logic [7:0] slot_addr(input int s);
    for (int a = 0; a < 256; a++)
      if (slot_of(8'(a)) == s) return 8'(a);
    return 8'h00;
  endfunction

  task automatic model_defaults();
    for (int i = 0; i < NR; i++) exp_r[i] = 8'h00;
    exp_r[3] = 8'h50;
    exp_r[9] = 8'h08;
  endtask

  task automatic model_write(input logic [7:0] a, input logic [7:0] d);
    int s;
    s = slot_of(a);
    if (a == 8'h00 && d[1]) model_defaults();
    else if (s >= 0 && (!exp_r[0][0] || a == 8'h00)) exp_r[s] = d;
  endtask

  function automatic logic [7:0] model_read(input logic [7:0] a);
    int s;
    s = slot_of(a);
    if (s <= 0) return 8'h00;
    return exp_r[s];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_checks++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic check_regs(input string req);
    for (int i = 0; i < NR; i++)
      check(req, 32'(regs_q[i*8 +: 8]), 32'(exp_r[i]));
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sel(input logic v);
    cfg_sel_n = v;
    wait_clk(HALF);
  endtask

  task automatic one_bit(input logic b, output logic so);
    cfg_sdi = b;
    cfg_sck = 1'b1;
    wait_clk(HALF);
    so = sdout_ovr;
    cfg_sck = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic frame(input logic [7:0] a, input logic [7:0] d, output logic [7:0] rb);
    logic [15:0] w;
    logic so;
    w = {a, d};
    rb = 8'h00;
    for (int i = 15; i >= 0; i--) begin
      one_bit(w[i], so);
      if (i < 8) rb[i] = so;
    end
  endtask

  task automatic write1(input logic [7:0] a, input logic [7:0] d);
    logic [7:0] rb;
    sel(1'b0);
    frame(a, d, rb);
    sel(1'b1);
    wait_clk(4);
    model_write(a, d);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] rb, a, d;
    logic so;
    void'($urandom(32'd20240611));
    wait_clk(5);
    hw_reset = 1'b0;
    wait_clk(5);
    model_defaults();
    check_regs("R1 reset defaults");
    check("R11 idle pin", 32'(sdout_ovr), 32'(ovr_flag));

    // R2 directed single write
    write1(8'h3F, 8'h2A);
    check_regs("R2 single frame");

    // R3 back-to-back frames in one select period, mixed with random stimulus
    for (int it = 0; it < 25; it++) begin
      int nf;
      nf = 1 + int'($urandom_range(2));
      sel(1'b0);
      for (int f = 0; f < nf; f++) begin
        int k;
        k = int'($urandom_range(9));
        if (k < 8) a = slot_addr(1 + int'($urandom_range(NR - 2)));
        else       a = 8'($urandom);
        if (a == 8'h00) a = 8'h01;
        d = 8'($urandom);
        frame(a, d, rb);
        model_write(a, d);
      end
      sel(1'b1);
      wait_clk(4);
      check_regs("R3 burst frames");
    end

    // R10 write to unimplemented address changes nothing
    write1(8'h77, 8'hFF);
    check_regs("R10 unmapped write");

    // R4 partial frame discarded, next period realigned
    sel(1'b0);
    frame(8'h25, 8'hA5, rb);
    model_write(8'h25, 8'hA5);
    for (int i = 0; i < 5; i++) one_bit(1'b1, so);
    sel(1'b1);
    wait_clk(4);
    check_regs("R4 partial tail");
    write1(8'h26, 8'h03);
    check_regs("R4 realigned frame");

    // R5 clock activity while deselected
    for (int i = 0; i < 20; i++) one_bit(1'($urandom), so);
    wait_clk(4);
    check_regs("R5 idle clocks");

    // R11 pin mirrors flag with readback off
    for (int i = 0; i < 4; i++) begin
      ovr_flag = 1'($urandom);
      wait_clk(2);
      check("R11 readback off", 32'(sdout_ovr), 32'(ovr_flag));
    end
    ovr_flag = 1'b0;

    // R9 readback mode
    write1(8'h00, 8'h01);
    check("R8 readback on", 32'(regs_q[0]), 32'd1);
    ovr_flag = 1'b1;
    wait_clk(2);
    check("R11 deselected in readback", 32'(sdout_ovr), 32'd1);
    ovr_flag = 1'b0;
    for (int it = 0; it < 12; it++) begin
      a = slot_addr(1 + int'($urandom_range(NR - 2)));
      sel(1'b0);
      frame(a, 8'($urandom), rb);
      sel(1'b1);
      wait_clk(4);
      check($sformatf("R9 readback %0h", a), 32'(rb), 32'(model_read(a)));
      check_regs("R7 locked during read");
    end
    sel(1'b0);
    frame(8'h00, 8'h01, rb);
    sel(1'b1);
    check("R10 read of control reads zero", 32'(rb), 32'd0);
    sel(1'b0);
    frame(8'h99, 8'h00, rb);
    sel(1'b1);
    check("R10 unmapped read", 32'(rb), 32'd0);
    // R9 two reads in one select period
    sel(1'b0);
    frame(8'h25, 8'h00, rb);
    check("R9 first of burst", 32'(rb), 32'(model_read(8'h25)));
    frame(8'h3F, 8'h00, rb);
    check("R9 second of burst", 32'(rb), 32'(model_read(8'h3F)));
    sel(1'b1);
    wait_clk(4);
    check_regs("R7 burst reads");

    // R8 leave readback through address 0
    write1(8'h00, 8'h00);
    check("R8 readback off", 32'(regs_q[0]), 32'd0);
    write1(8'h43, 8'h11);
    check_regs("R8 writes reopened");

    // R6 software reset, also from readback mode
    write1(8'h01, 8'hFC);
    write1(8'h00, 8'h02);
    check_regs("R6 soft reset");
    write1(8'hCF, 8'h3C);
    write1(8'h00, 8'h01);
    write1(8'h00, 8'h03);
    check_regs("R6 soft reset in readback");
    check("R6 control cleared", 32'(regs_q[7:0]), 32'd0);

    // R1 hardware reset again
    write1(8'h42, 8'h00);
    @(negedge clk); hw_reset = 1'b1;
    wait_clk(3);
    hw_reset = 1'b0;
    wait_clk(3);
    model_defaults();
    check_regs("R1 hw reset pulse");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule